// File: doc/BRIEF.md
# Word-Wise Frame CRC-32 Inserter and Checker

This block runs a 32-bit CRC over the payload words of a link-layer frame, one whole word per clock. Upstream logic presents a stream of words with flags marking start-of-frame, end-of-frame, CONT and other primitives. Every word passes through to the output one cycle later. The CRC covers only payload words inside a frame. It leaves out all primitives and any filler words that follow a CONT.

With `mode_rx` low, the block transmits. It appends the computed CRC as a data word directly after the last payload word and delays the EOF by one cycle to make room for it. The source must leave the cycle after an EOF idle. With `mode_rx` high, the block receives. It treats the last payload word before EOF as the received CRC and issues a one-cycle `crc_ok` or `crc_err` pulse together with the outgoing EOF.

The controller has four states:
- `S_IDLE`: outside a frame.
- `S_DATA`: inside a frame, folding payload words into the CRC.
- `S_HOLD`: inside a frame after a CONT, where filler words are skipped.
- `S_TAIL`: transmit only, emitting the EOF that was held back.

The transitions are:
- SOF from any state except `S_TAIL` goes to `S_DATA` and reseeds the CRC.
- CONT in a frame goes to `S_HOLD`.
- Another primitive in `S_HOLD` goes back to `S_DATA`.
- EOF goes to `S_TAIL` when a transmit frame has payload, and to `S_IDLE` in every other case.
- `S_TAIL` always goes to `S_IDLE`.

Top module: `frame_crc32`

## Requirements
- R1: The CRC step uses the generator 0x04C11DB7 (x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1). Input bits are taken from bit 0 up to bit 31. For each bit, the feedback is crc[31] XOR the data bit; the register shifts left and is XORed with the generator when the feedback is 1. There is no reflection and no final inversion.
- R2: Every SOF loads the seed 0x52325032, including an SOF that arrives inside a frame, which restarts the frame.
- R3: The CRC skips words flagged SOF, EOF, CONT or primitive. The flag priority is SOF, then EOF, then CONT, then primitive. These words reach the output unchanged.
- R4: After a CONT inside a frame, unflagged words are filler. Filler does not change the CRC until the next primitive.
- R5: In transmit mode, an EOF ending a frame with payload produces two outputs. First comes a data word (no flags) carrying the CRC of all payload words. The EOF follows on the next cycle.
- R6: In receive mode, the CRC covers every payload word except the last one before EOF. A match between that last word and the CRC gives `crc_ok` for one cycle, in the same cycle as `out_eof`.
- R7: In receive mode, a mismatch gives `crc_err` for one cycle, in the same cycle as `out_eof`.
- R8: An EOF outside a frame gives `crc_err` with the EOF, in either mode.
- R9: A frame with no payload words gives `crc_err` at its EOF. In transmit mode no CRC word is inserted.
- R10: Every input word except an inserted CRC appears on the output exactly one cycle later, with its flags. `crc_ok` and `crc_err` are never high together, and never high without `out_eof`.
- R11: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rx | input | 1 | 1 = check (receive), 0 = insert (transmit) |
| in_valid | input | 1 | Input word present |
| in_data | input | 32 | Input word |
| in_sof | input | 1 | Word is start-of-frame |
| in_eof | input | 1 | Word is end-of-frame |
| in_prim | input | 1 | Word is some other primitive |
| in_cont | input | 1 | Word is a CONT primitive |
| out_valid | output | 1 | Output word present |
| out_data | output | 32 | Output word |
| out_sof | output | 1 | Output is start-of-frame |
| out_eof | output | 1 | Output is end-of-frame |
| out_prim | output | 1 | Output is other primitive |
| out_cont | output | 1 | Output is CONT |
| crc_ok | output | 1 | Receive check passed |
| crc_err | output | 1 | Check failed or framing error |

## Verification
The bench covers several ways the block can go wrong:
- **Filler after CONT:** a design that folded filler into the CRC would produce a wrong inserted word or a spurious `crc_err`.
- **HOLD-style primitives inside a frame:** a design that folded them in would fail in the same way.
- **SOF inside a frame:** a design that kept the old CRC running would give a wrong CRC for the restarted frame.
- **Received CRC word:** a design that also folded the received CRC word into the running CRC would never report `crc_ok`.
- **Stray EOF and empty frames:** a controller that ignored frame state would stay silent on a stray EOF, or insert a seed-valued CRC into an empty frame.
- **EOF timing after insertion:** the bench checks that the held EOF arrives exactly one cycle after the inserted word, so an off-by-one tail would shift or lose the EOF.

// File: rtl/frame_crc32_pkg.sv
package frame_crc32_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DATA = 2'd1,
        S_HOLD = 2'd2,
        S_TAIL = 2'd3
    } fstate_e;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_SOF  = 3'd1,
        K_EOF  = 3'd2,
        K_CONT = 3'd3,
        K_PRIM = 3'd4,
        K_DATA = 3'd5
    } kind_e;

endpackage

// File: rtl/frame_crc32_engine.sv
module frame_crc32_engine #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C1_1DB7,
    parameter logic [W-1:0] SEED = 32'h5232_5032
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc_q
);

    logic [W-1:0] chain [0:W];

    assign chain[0] = crc_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign chain[i+1] = {chain[i][W-2:0], 1'b0}
                          ^ ((chain[i][W-1] ^ din[i]) ? POLY : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= SEED;
        else if (load)  crc_q <= SEED;
        else if (step)  crc_q <= chain[W];
    end

    p_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (crc_q == SEED));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(crc_q));

endmodule

// File: rtl/frame_crc32_ctrl.sv
module frame_crc32_ctrl
    import frame_crc32_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_rx,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_eof,
    input  logic in_prim,
    input  logic in_cont,
    output logic crc_load,
    output logic crc_step,
    output logic pend_we,
    output logic emit_crc,
    output logic in_tail,
    output logic chk,
    output logic err
);

    fstate_e st_q, st_d;
    kind_e   kind;
    logic    got_q, got_set, got_clr;

    always_comb begin
        if (!in_valid)    kind = K_NONE;
        else if (in_sof)  kind = K_SOF;
        else if (in_eof)  kind = K_EOF;
        else if (in_cont) kind = K_CONT;
        else if (in_prim) kind = K_PRIM;
        else              kind = K_DATA;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            got_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (got_clr)      got_q <= 1'b0;
            else if (got_set) got_q <= 1'b1;
        end
    end

    always_comb begin
        st_d     = st_q;
        crc_load = 1'b0;
        crc_step = 1'b0;
        pend_we  = 1'b0;
        emit_crc = 1'b0;
        chk      = 1'b0;
        err      = 1'b0;
        got_set  = 1'b0;
        got_clr  = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (kind == K_SOF) begin
                    crc_load = 1'b1;
                    got_clr  = 1'b1;
                    st_d     = S_DATA;
                end else if (kind == K_EOF) begin
                    err = 1'b1;
                end
            end
            S_DATA, S_HOLD: begin
                case (kind)
                    K_SOF: begin
                        crc_load = 1'b1;
                        got_clr  = 1'b1;
                        st_d     = S_DATA;
                    end
                    K_EOF: begin
                        if (!got_q) begin
                            err  = 1'b1;
                            st_d = S_IDLE;
                        end else if (mode_rx) begin
                            chk  = 1'b1;
                            st_d = S_IDLE;
                        end else begin
                            emit_crc = 1'b1;
                            st_d     = S_TAIL;
                        end
                    end
                    K_CONT: st_d = S_HOLD;
                    K_PRIM: st_d = S_DATA;
                    K_DATA: begin
                        if (st_q == S_DATA) begin
                            got_set = 1'b1;
                            if (mode_rx) begin
                                crc_step = got_q;
                                pend_we  = 1'b1;
                            end else begin
                                crc_step = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            S_TAIL: st_d = S_IDLE;
        endcase
    end

    assign in_tail = (st_q == S_TAIL);

    p_tail_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_TAIL) |=> (st_q == S_IDLE));

    p_hold_from_cont_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q == S_HOLD)) |-> $past(in_valid && in_cont && !in_sof && !in_eof));

endmodule

// File: rtl/frame_crc32.sv
module frame_crc32 #(
    parameter int          W    = 32,
    parameter logic [W-1:0] POLY = 32'h04C1_1DB7,
    parameter logic [W-1:0] SEED = 32'h5232_5032
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_rx,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         in_sof,
    input  logic         in_eof,
    input  logic         in_prim,
    input  logic         in_cont,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    output logic         out_sof,
    output logic         out_eof,
    output logic         out_prim,
    output logic         out_cont,
    output logic         crc_ok,
    output logic         crc_err
);

    logic         crc_load, crc_step, pend_we, emit_crc, in_tail, chk, err;
    logic [W-1:0] crc_q, pend_q, tail_q, step_din;

    frame_crc32_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_rx  (mode_rx),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_prim  (in_prim),
        .in_cont  (in_cont),
        .crc_load (crc_load),
        .crc_step (crc_step),
        .pend_we  (pend_we),
        .emit_crc (emit_crc),
        .in_tail  (in_tail),
        .chk      (chk),
        .err      (err)
    );

    assign step_din = mode_rx ? pend_q : in_data;

    frame_crc32_engine #(.W(W), .POLY(POLY), .SEED(SEED)) eng_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (crc_load),
        .step  (crc_step),
        .din   (step_din),
        .crc_q (crc_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            tail_q <= '0;
        end else begin
            if (pend_we)  pend_q <= in_data;
            if (emit_crc) tail_q <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_prim  <= 1'b0;
            out_cont  <= 1'b0;
            crc_ok    <= 1'b0;
            crc_err   <= 1'b0;
        end else if (in_tail) begin
            out_valid <= 1'b1;
            out_data  <= tail_q;
            out_sof   <= 1'b0;
            out_eof   <= 1'b1;
            out_prim  <= 1'b0;
            out_cont  <= 1'b0;
            crc_ok    <= 1'b0;
            crc_err   <= 1'b0;
        end else if (emit_crc) begin
            out_valid <= 1'b1;
            out_data  <= crc_q;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_prim  <= 1'b0;
            out_cont  <= 1'b0;
            crc_ok    <= 1'b0;
            crc_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_data;
            out_sof   <= in_valid & in_sof;
            out_eof   <= in_valid & in_eof;
            out_prim  <= in_valid & in_prim;
            out_cont  <= in_valid & in_cont;
            crc_ok    <= chk & (pend_q == crc_q);
            crc_err   <= err | (chk & (pend_q != crc_q));
        end
    end

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_ok && crc_err));

    p_pulse_at_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_ok || crc_err) |-> (out_valid && out_eof));

    p_tail_eof_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_tail |=> (out_valid && out_eof && !out_sof));

    p_crc_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        emit_crc |=> (out_valid && !out_eof && !out_sof && !out_prim && !out_cont));

    p_stray_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !in_tail) |=> crc_err);

endmodule

// File: tb/frame_crc32_tb_top.sv
module frame_crc32_tb_top;

    localparam logic [31:0] GEN  = 32'h04C1_1DB7;
    localparam logic [31:0] INIT = 32'h5232_5032;

    typedef struct {
        logic [31:0] d;
        logic        s, e, p, c, ok, er;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_rx = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_sof = 1'b0, in_eof = 1'b0, in_prim = 1'b0, in_cont = 1'b0;
    logic        out_valid, out_sof, out_eof, out_prim, out_cont, crc_ok, crc_err;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];
    exp_t cur;
    bit done = 1'b0;

    logic        m_in, m_hold, m_got;
    logic [31:0] m_crc, m_pend;

    always #4 clk = ~clk;

    frame_crc32 dut_i (
        .clk(clk), .rst_n(rst_n), .mode_rx(mode_rx),
        .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_prim(in_prim), .in_cont(in_cont),
        .out_valid(out_valid), .out_data(out_data),
        .out_sof(out_sof), .out_eof(out_eof), .out_prim(out_prim), .out_cont(out_cont),
        .crc_ok(crc_ok), .crc_err(crc_err)
    );

    function automatic logic [31:0] ref_step(logic [31:0] c, logic [31:0] d);
        logic [31:0] r = c;
        for (int i = 0; i < 32; i++) begin
            logic fb = r[31] ^ d[i];
            r = {r[30:0], 1'b0} ^ (fb ? GEN : 32'h0);
        end
        return r;
    endfunction

    function automatic exp_t mk(logic [31:0] d, logic s, logic e, logic p, logic c,
                                logic ok, logic er, string tag);
        exp_t x;
        x.d = d; x.s = s; x.e = e; x.p = p; x.c = c; x.ok = ok; x.er = er; x.tag = tag;
        return x;
    endfunction

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_data = '0;
        in_sof = 1'b0; in_eof = 1'b0; in_prim = 1'b0; in_cont = 1'b0;
    endtask

    task automatic put(logic [31:0] d, logic s, logic e, logic p, logic c, string tag);
        bit tail = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        in_sof = s; in_eof = e; in_prim = p; in_cont = c;
        if (s) begin
            m_in = 1'b1; m_hold = 1'b0; m_got = 1'b0; m_crc = INIT;
            q.push_back(mk(d, s, e, p, c, 1'b0, 1'b0, tag));
        end else if (e) begin
            if (!m_in || !m_got) begin
                q.push_back(mk(d, s, e, p, c, 1'b0, 1'b1, tag));
            end else if (mode_rx) begin
                q.push_back(mk(d, s, e, p, c, m_pend == m_crc, m_pend != m_crc, tag));
            end else begin
                q.push_back(mk(m_crc, 0, 0, 0, 0, 0, 0, tag));
                q.push_back(mk(d, 0, 1, 0, 0, 0, 0, tag));
                tail = 1'b1;
            end
            m_in = 1'b0;
        end else if (c) begin
            if (m_in) m_hold = 1'b1;
            q.push_back(mk(d, s, e, p, c, 1'b0, 1'b0, tag));
        end else if (p) begin
            m_hold = 1'b0;
            q.push_back(mk(d, s, e, p, c, 1'b0, 1'b0, tag));
        end else begin
            if (m_in && !m_hold) begin
                if (mode_rx) begin
                    if (m_got) m_crc = ref_step(m_crc, m_pend);
                    m_pend = d;
                end else begin
                    m_crc = ref_step(m_crc, d);
                end
                m_got = 1'b1;
            end
            q.push_back(mk(d, s, e, p, c, 1'b0, 1'b0, tag));
        end
        if (tail) idle();
    endtask

    task automatic fail_line(string tag, string what, logic [31:0] act, logic [31:0] exp);
        fails++;
        $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                checks++;
                if (q.size() == 0) begin
                    fail_line("R10", "unexpected output word", out_data, 32'h0);
                end else begin
                    cur = q.pop_front();
                    if ({out_data, out_sof, out_eof, out_prim, out_cont, crc_ok, crc_err} !==
                        {cur.d, cur.s, cur.e, cur.p, cur.c, cur.ok, cur.er})
                        fail_line(cur.tag, "word/flags/result",
                                  {out_data[25:0], out_sof, out_eof, out_prim, out_cont, crc_ok, crc_err},
                                  {cur.d[25:0], cur.s, cur.e, cur.p, cur.c, cur.ok, cur.er});
                end
            end else if (crc_ok || crc_err) begin
                checks++;
                fail_line("R10", "pulse without EOF", {30'h0, crc_ok, crc_err}, 32'h0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rc;
        m_in = 0; m_hold = 0; m_got = 0; m_crc = INIT; m_pend = 0;
        repeat (3) @(negedge clk);
        checks++; // R11 reset state
        if ({out_valid, out_sof, out_eof, out_prim, out_cont, crc_ok, crc_err} !== 7'b0 || out_data !== 32'h0)
            fail_line("R11", "reset outputs", out_data, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        idle();

        // R1 R5: plain transmit frame
        mode_rx = 1'b0;
        put(32'hAAAA_0001, 1, 0, 0, 0, "R2");
        put(32'h1234_5678, 0, 0, 0, 0, "R10");
        put(32'hDEAD_BEEF, 0, 0, 0, 0, "R10");
        put(32'h0000_0000, 0, 0, 0, 0, "R10");
        put(32'hEEEE_0002, 0, 1, 0, 0, "R5");
        idle();

        // R3: primitives inside a transmit frame
        put(32'h1, 1, 0, 0, 0, "R2");
        put(32'hCAFE_0001, 0, 0, 0, 0, "R3");
        put(32'h7777_7777, 0, 0, 1, 0, "R3");
        put(32'h7777_7777, 0, 0, 1, 0, "R3");
        put(32'hCAFE_0002, 0, 0, 0, 0, "R3");
        put(32'h2, 0, 1, 0, 0, "R3");

        // R4: CONT filler in transmit
        put(32'h1, 1, 0, 0, 0, "R2");
        put(32'h0BAD_F00D, 0, 0, 0, 0, "R4");
        put(32'h5555_5555, 0, 0, 0, 1, "R4");
        put(32'hFFFF_0000, 0, 0, 0, 0, "R4");
        put(32'hFFFF_0001, 0, 0, 0, 0, "R4");
        put(32'h6666_6666, 0, 0, 1, 0, "R4");
        put(32'h0000_1111, 0, 0, 0, 0, "R4");
        put(32'h2, 0, 1, 0, 0, "R4");

        // R2: SOF mid-frame restarts
        put(32'h1, 1, 0, 0, 0, "R2");
        put(32'h9999_9999, 0, 0, 0, 0, "R2");
        put(32'h1, 1, 0, 0, 0, "R2");
        put(32'h4242_4242, 0, 0, 0, 0, "R2");
        put(32'h2, 0, 1, 0, 0, "R2");

        // R8 R9 in transmit
        put(32'h3, 0, 1, 0, 0, "R8");
        put(32'h1, 1, 0, 0, 0, "R9");
        put(32'h2, 0, 1, 0, 0, "R9");
        put(32'h0123_4567, 0, 0, 0, 0, "R10");
        idle();

        // R6: receive, correct CRC
        mode_rx = 1'b1;
        rc = ref_step(ref_step(INIT, 32'h1111_2222), 32'h3333_4444);
        put(32'h1, 1, 0, 0, 0, "R2");
        put(32'h1111_2222, 0, 0, 0, 0, "R6");
        put(32'h8888_8888, 0, 0, 1, 0, "R6");
        put(32'h3333_4444, 0, 0, 0, 0, "R6");
        put(rc, 0, 0, 0, 0, "R6");
        put(32'h2, 0, 1, 0, 0, "R6");

        // R7: receive, corrupted CRC
        put(32'h1, 1, 0, 0, 0, "R2");
        put(32'h1111_2222, 0, 0, 0, 0, "R7");
        put(32'h3333_4444, 0, 0, 0, 0, "R7");
        put(rc ^ 32'h0000_0100, 0, 0, 0, 0, "R7");
        put(32'h2, 0, 1, 0, 0, "R7");

        // R4: receive with CONT filler, correct CRC
        rc = ref_step(INIT, 32'hABCD_0123);
        put(32'h1, 1, 0, 0, 0, "R2");
        put(32'hABCD_0123, 0, 0, 0, 0, "R4");
        put(32'h5, 0, 0, 0, 1, "R4");
        put(32'hFEED_FEED, 0, 0, 0, 0, "R4");
        put(32'h6, 0, 0, 1, 0, "R4");
        put(rc, 0, 0, 0, 0, "R4");
        put(32'h2, 0, 1, 0, 0, "R4");

        // R8 R9 in receive; CRC-only frame checks against the seed
        put(32'h3, 0, 1, 0, 0, "R8");
        put(32'h1, 1, 0, 0, 0, "R9");
        put(32'h2, 0, 1, 0, 0, "R9");
        put(32'h1, 1, 0, 0, 0, "R6");
        put(INIT, 0, 0, 0, 0, "R6");
        put(32'h2, 0, 1, 0, 0, "R6");
        idle();
        repeat (4) idle();

        checks++; // R10 every expected word appeared
        if (q.size() != 0) fail_line("R10", "words never produced", q.size(), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule